// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block takes the error-correction code recomputed while a flash page chunk was read and the code that was stored with that chunk, and decides what went wrong. Each 256-byte chunk carries a 3-byte code. The block XORs the two codes into a syndrome and sorts the outcome into four classes: clean, damaged code field, correctable single data bit, and uncorrectable. For a correctable chunk it reports where the bad bit sits. It also returns the byte it was handed with that bit inverted, so the caller can write the fix back.

In wide mode the block evaluates two consecutive 256-byte halves in one go. Each half has its own 3-byte code and its own candidate byte. The two results merge into one status and a count of corrected bits. A pulse on `start` captures all inputs. The results appear one clock later, with a one-cycle `done` strobe, and stay unchanged until the next pulse.

Top module: `ecc_syndrome_fix`

## Requirements
- R1: After reset, `done` is 0, `status` is 0, `flips` is 0, and `err_byte`, `err_bit` and `data_out` are all zero.
- R2: A `start` pulse captured on a clock edge makes `done` high for exactly the following cycle. All result outputs change only on edges where `start` is sampled high.
- R3: A half is clean (status code 0) when its syndrome is zero, or its calculated code is zero, or its stored code is zero. A clean half passes its data byte through unchanged and reports index zero.
- R4: Each half's code is the 24-bit little-endian value of its 3 code bytes: half 0 uses `calc_code[23:0]`/`stored_code[23:0]` and half 1 uses bits [47:24]. A syndrome with exactly one bit set, in any of the 24 positions, gives status code 2 (damaged code field). The data byte is not altered.
- R5: A syndrome with exactly 11 set bits is correctable (status code 1) when (calc[10:0]^calc[21:11])^(stored[10:0]^stored[21:11]) equals 0x7FF. The bit index is syndrome[2:0] and the byte index is syndrome[10:3]. The half's output byte is its input byte with that bit inverted.
- R6: Any other syndrome gives status code 3 (uncorrectable), including 11 set bits that fail the pair test. The byte index and bit index are zero and the data byte is unchanged.
- R7: With `wide_mode`=1, half 1 is evaluated with code bits [47:24] and data byte `data_in[15:8]`. When neither half fails, `flips` is the number of corrected halves (0 to 2), and `status` is 1 if any half was corrected and 0 otherwise.
- R8: If a half is in class 2 or 3, `status` takes the class of the lowest-numbered failing half and `flips` is 0. Each half's output byte still follows its own class.
- R9: With `wide_mode`=0, the half 1 code and data inputs have no effect. `data_out[15:8]` equals `data_in[15:8]`, the half 1 indices are zero, and `status` and `flips` depend on half 0 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture pulse for one evaluation |
| wide_mode | input | 1 | 1: two halves (512-byte chunk), 0: half 0 only |
| calc_code | input | 48 | Recomputed code bytes; byte k at bits [8k+7:8k] |
| stored_code | input | 48 | Code bytes read from the spare area, same layout |
| data_in | input | 16 | Candidate data byte per half (half 1 in [15:8]) |
| done | output | 1 | One-cycle strobe, results valid |
| status | output | 2 | 0 clean, 1 corrected, 2 code field damaged, 3 uncorrectable |
| flips | output | 2 | Number of corrected bits |
| err_byte | output | 16 | Failing byte index per half (half 1 in [15:8]) |
| err_bit | output | 6 | Failing bit index per half (half 1 in [5:3]) |
| data_out | output | 16 | Data byte per half with the fix applied |

## Verification
In wide mode, two corrections, or a correction and a failure, land in the same capture cycle and must be merged. The bench provokes both cases. It builds two independently placed single-bit syndromes in the two halves of one start pulse, and checks that `flips` reads 2 and that both output bytes carry their own inverted bit. It then pairs a correctable half 0 with a failing half 1, and a damaged half 0 with an uncorrectable half 1. In those cases the bench judges that the failing class wins in half order, that the flip count drops to zero, and that half 0's byte still shows its fix.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int PAR_W  = 11;
  localparam int CODE_W = 24;
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int BYTE_W = PAR_W - BIT_W;
  localparam int CNT_W  = $clog2(CODE_W + 1);

  typedef enum logic [1:0] {
    ECC_CLEAN    = 2'd0,
    ECC_FIXED    = 2'd1,
    ECC_CODE_BAD = 2'd2,
    ECC_UNCORR   = 2'd3
  } ecc_cls_e;

  function automatic logic [CNT_W-1:0] ones_of(input logic [CODE_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < CODE_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [PAR_W-1:0] fold_pairs(input logic [CODE_W-1:0] c);
    return c[PAR_W-1:0] ^ c[2*PAR_W-1:PAR_W];
  endfunction

  function automatic logic [DATA_W-1:0] flip_bit(input logic [DATA_W-1:0] d,
                                                 input logic [BIT_W-1:0] pos,
                                                 input logic en);
    return en ? (d ^ (DATA_W'(1) << pos)) : d;
  endfunction
endpackage

// File: rtl/ecc_half_eval.sv
module ecc_half_eval
  import ecc_fix_pkg::*;
(
  input  logic              active,
  input  logic [CODE_W-1:0] calc,
  input  logic [CODE_W-1:0] stored,
  output ecc_cls_e          cls,
  output logic [BYTE_W-1:0] byte_idx,
  output logic [BIT_W-1:0]  bit_idx
);
  logic [CODE_W-1:0] syn;
  logic [CNT_W-1:0]  weight;
  logic              pairs_split;
  logic              quiet;

  assign syn         = calc ^ stored;
  assign weight      = ones_of(syn);
  assign pairs_split = (fold_pairs(calc) ^ fold_pairs(stored)) == {PAR_W{1'b1}};
  assign quiet       = !active || (syn == '0) || (calc == '0) || (stored == '0);

  always_comb begin
    cls = ECC_UNCORR;
    if (quiet)                                          cls = ECC_CLEAN;
    else if (weight == CNT_W'(1))                       cls = ECC_CODE_BAD;
    else if ((weight == CNT_W'(PAR_W)) && pairs_split)  cls = ECC_FIXED;
  end

  assign byte_idx = (cls == ECC_FIXED) ? syn[PAR_W-1:BIT_W] : '0;
  assign bit_idx  = (cls == ECC_FIXED) ? syn[BIT_W-1:0]     : '0;
endmodule

// File: rtl/ecc_merge.sv
module ecc_merge
  import ecc_fix_pkg::*;
#(
  parameter  int HALVES = 2,
  localparam int FLIP_W = $clog2(HALVES + 1)
) (
  input  ecc_cls_e          cls [HALVES],
  output ecc_cls_e          status,
  output logic [FLIP_W-1:0] flips
);
  always_comb begin
    logic failed;
    failed = 1'b0;
    status = ECC_CLEAN;
    flips  = '0;
    for (int h = 0; h < HALVES; h++) begin
      if (!failed && (cls[h] == ECC_CODE_BAD || cls[h] == ECC_UNCORR)) begin
        failed = 1'b1;
        status = cls[h];
      end else if (!failed && cls[h] == ECC_FIXED) begin
        status = ECC_FIXED;
        flips  = flips + FLIP_W'(1);
      end
    end
    if (failed) flips = '0;
  end
endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
  import ecc_fix_pkg::*;
#(
  parameter  int HALVES = 2,
  localparam int FLIP_W = $clog2(HALVES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       wide_mode,
  input  logic [HALVES*CODE_W-1:0]   calc_code,
  input  logic [HALVES*CODE_W-1:0]   stored_code,
  input  logic [HALVES*DATA_W-1:0]   data_in,
  output logic                       done,
  output logic [1:0]                 status,
  output logic [FLIP_W-1:0]          flips,
  output logic [HALVES*BYTE_W-1:0]   err_byte,
  output logic [HALVES*BIT_W-1:0]    err_bit,
  output logic [HALVES*DATA_W-1:0]   data_out
);
  ecc_cls_e                  cls_w [HALVES];
  logic [BYTE_W-1:0]         byte_w [HALVES];
  logic [BIT_W-1:0]          bit_w [HALVES];
  logic [HALVES-1:0]         hit_w;
  logic [HALVES-1:0]         fail_w;
  logic [HALVES*BYTE_W-1:0]  byte_flat;
  logic [HALVES*BIT_W-1:0]   bit_flat;
  logic [HALVES*DATA_W-1:0]  fix_flat;
  ecc_cls_e                  status_w;
  logic [FLIP_W-1:0]         flips_w;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic act;
    assign act = (h == 0) ? 1'b1 : wide_mode;

    ecc_half_eval u_eval (
      .active   (act),
      .calc     (calc_code[h*CODE_W +: CODE_W]),
      .stored   (stored_code[h*CODE_W +: CODE_W]),
      .cls      (cls_w[h]),
      .byte_idx (byte_w[h]),
      .bit_idx  (bit_w[h])
    );

    assign hit_w[h]  = (cls_w[h] == ECC_FIXED);
    assign fail_w[h] = (cls_w[h] == ECC_CODE_BAD) || (cls_w[h] == ECC_UNCORR);
    assign byte_flat[h*BYTE_W +: BYTE_W] = byte_w[h];
    assign bit_flat[h*BIT_W +: BIT_W]    = bit_w[h];
    assign fix_flat[h*DATA_W +: DATA_W]  =
      flip_bit(data_in[h*DATA_W +: DATA_W], bit_w[h], hit_w[h]);

    if (h > 0) begin : g_quiet
      AST_NARROW_HALF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done && !$past(wide_mode) |->
          data_out[h*DATA_W +: DATA_W] == $past(data_in[h*DATA_W +: DATA_W]) &&
          err_byte[h*BYTE_W +: BYTE_W] == '0); // R9
    end
  end

  ecc_merge #(.HALVES(HALVES)) u_merge (
    .cls    (cls_w),
    .status (status_w),
    .flips  (flips_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status   <= 2'(ECC_CLEAN);
      flips    <= '0;
      err_byte <= '0;
      err_bit  <= '0;
      data_out <= '0;
    end else begin
      done <= start;
      if (start) begin
        status   <= 2'(status_w);
        flips    <= flips_w;
        err_byte <= byte_flat;
        err_bit  <= bit_flat;
        data_out <= fix_flat;
      end
    end
  end

  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R2
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start)); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(status) && $stable(flips) && $stable(data_out)); // R2
  AST_FAIL_ZERO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    start && (|fail_w) |=> status[1] && flips == '0); // R8
  AST_CLEAN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 2'(ECC_CLEAN) |-> data_out == $past(data_in) && flips == '0); // R3
  AST_FIX_FLIP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == 2'(ECC_FIXED) |->
      $countones(data_out ^ $past(data_in)) == int'(flips) && flips != '0); // R5
endmodule

// File: tb/ecc_syndrome_fix_bench.sv
module ecc_syndrome_fix_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        wide_mode = 1'b0;
  logic [47:0] calc_code = '0;
  logic [47:0] stored_code = '0;
  logic [15:0] data_in = '0;
  logic        done;
  logic [1:0]  status;
  logic [1:0]  flips;
  logic [15:0] err_byte;
  logic [5:0]  err_bit;
  logic [15:0] data_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ecc_syndrome_fix u_ecc_syndrome_fix (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_mode(wide_mode),
    .calc_code(calc_code), .stored_code(stored_code), .data_in(data_in),
    .done(done), .status(status), .flips(flips), .err_byte(err_byte),
    .err_bit(err_bit), .data_out(data_out)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int weight(input logic [23:0] v);
    logic [23:0] t;
    int n;
    t = v;
    n = 0;
    while (t != 0) begin
      t = t & (t - 24'd1);
      n++;
    end
    return n;
  endfunction

  // class: 0 clean, 1 corrected, 2 code damaged, 3 uncorrectable
  task automatic half_ref(input logic act, input logic [23:0] c, input logic [23:0] s,
                          output logic [1:0] k, output logic [10:0] loc);
    logic [23:0] x;
    x   = c ^ s;
    loc = x[10:0];
    if (!act || x == 0 || c == 0 || s == 0) k = 2'd0;
    else if (weight(x) == 1) k = 2'd2;
    else if (weight(x) == 11 &&
             ((c[10:0] ^ s[10:0]) ^ (c[21:11] ^ s[21:11])) == 11'h7FF) k = 2'd1;
    else k = 2'd3;
  endtask

  // stored code that puts a single data-bit error at (byt, bt) against calc c
  function automatic logic [23:0] bad_bit(input logic [23:0] c, input logic [7:0] byt,
                                          input logic [2:0] bt);
    logic [10:0] l;
    l = {byt, bt};
    return c ^ {2'b00, ~l, l};
  endfunction

  task automatic run_case(input string req, input logic wide, input logic [47:0] c,
                          input logic [47:0] s, input logic [15:0] d);
    logic [1:0]  k [2];
    logic [10:0] loc [2];
    logic [1:0]  st, fl;
    logic [15:0] eb, dq;
    logic [5:0]  ebt;
    for (int h = 0; h < 2; h++) half_ref(h == 0 || wide, c[h*24 +: 24], s[h*24 +: 24], k[h], loc[h]);
    if (k[0] >= 2) st = k[0];
    else if (k[1] >= 2) st = k[1];
    else st = (k[0] == 1 || k[1] == 1) ? 2'd1 : 2'd0;
    fl = (st >= 2) ? 2'd0 : 2'(int'(k[0] == 1) + int'(k[1] == 1));
    for (int h = 0; h < 2; h++) begin
      eb[h*8 +: 8]  = (k[h] == 1) ? loc[h][10:3] : 8'd0;
      ebt[h*3 +: 3] = (k[h] == 1) ? loc[h][2:0] : 3'd0;
      dq[h*8 +: 8]  = (k[h] == 1) ? (d[h*8 +: 8] ^ (8'd1 << loc[h][2:0])) : d[h*8 +: 8];
    end
    @(negedge clk);
    wide_mode = wide; calc_code = c; stored_code = s; data_in = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "done", 32'(done), 32'd1);
    chk(req, "status", 32'(status), 32'(st));
    chk(req, "flips", 32'(flips), 32'(fl));
    chk(req, "err_byte", 32'(err_byte), 32'(eb));
    chk(req, "err_bit", 32'(err_bit), 32'(ebt));
    chk(req, "data_out", 32'(data_out), 32'(dq));
    // scramble inputs without start: outputs must hold
    calc_code = ~c; stored_code = 48'h1; data_in = ~d;
    @(negedge clk);
    chk("R2", "done low", 32'(done), 32'd0);
    chk("R2", "held data", 32'(data_out), 32'(dq));
    chk("R2", "held status", 32'(status), 32'(st));
  endtask

  task automatic t_reset;
    chk("R1", "done", 32'(done), 32'd0);
    chk("R1", "status", 32'(status), 32'd0);
    chk("R1", "flips", 32'(flips), 32'd0);
    chk("R1", "err_byte", 32'(err_byte), 32'd0);
    chk("R1", "err_bit", 32'(err_bit), 32'd0);
    chk("R1", "data_out", 32'(data_out), 32'd0);
  endtask

  task automatic t_clean;
    run_case("R3", 1'b0, 48'h0000_0012_3456, 48'h0000_0012_3456, 16'h00A5);
    run_case("R3", 1'b0, 48'h0, 48'h0000_0000_0F0F, 16'h003C);
    run_case("R3", 1'b0, 48'h0000_0077_0001, 48'h0, 16'h0081);
    chk("R3", "clean data kept", 32'(data_out), 32'h0081);
  endtask

  task automatic t_code_bad;
    run_case("R4", 1'b0, 48'h0000_0012_3456, 48'h0000_0012_3457, 16'h0055);
    run_case("R4", 1'b0, 48'h0000_0012_3456, 48'h0000_0052_3456, 16'h00F0);
    chk("R4", "class code 2", 32'(status), 32'd2);
  endtask

  task automatic t_single_fix;
    run_case("R5", 1'b0, 48'h0000_0012_3456, {24'h0, bad_bit(24'h123456, 8'h00, 3'd0)}, 16'h0000);
    chk("R5", "bit0 fixed", 32'(data_out), 32'h0001);
    run_case("R5", 1'b0, 48'h0000_0012_3456, {24'h0, bad_bit(24'h123456, 8'hFF, 3'd7)}, 16'h00FF);
    chk("R5", "bit7 fixed", 32'(data_out), 32'h007F);
    run_case("R5", 1'b0, 48'h0000_00AB_CDEF, {24'h0, bad_bit(24'hABCDEF, 8'h5A, 3'd3)}, 16'h0033);
    chk("R5", "byte idx", 32'(err_byte), 32'h005A);
  endtask

  task automatic t_uncorr;
    // 11 bits set but pairs agree in places: 0x3F low, 0x1F high
    run_case("R6", 1'b0, 48'h0000_0012_3456, 48'h0000_0012_3456 ^ {24'h0, 2'b00, 11'h01F, 11'h03F}, 16'h0099);
    chk("R6", "class code 3", 32'(status), 32'd3);
    run_case("R6", 1'b0, 48'h0000_0012_3456, 48'h0000_0012_3450, 16'h0011);
  endtask

  task automatic t_wide_both;
    run_case("R7", 1'b1, {24'h345678, 24'h123456},
             {bad_bit(24'h345678, 8'h21, 3'd6), bad_bit(24'h123456, 8'h04, 3'd2)}, 16'h0F0F);
    chk("R7", "two flips", 32'(flips), 32'd2);
    run_case("R7", 1'b1, {24'h345678, 24'h123456},
             {bad_bit(24'h345678, 8'h80, 3'd1), 24'h123456}, 16'hAA55);
    chk("R7", "half1 only", 32'(data_out), 32'hA855);
  endtask

  task automatic t_wide_fail;
    run_case("R8", 1'b1, {24'h345678, 24'h123456},
             {24'h345678 ^ 24'h000003, bad_bit(24'h123456, 8'h10, 3'd5)}, 16'h0000);
    chk("R8", "half0 still fixed", 32'(data_out), 32'h0020);
    run_case("R8", 1'b1, {24'h345678, 24'h123456},
             {24'h345678 ^ 24'h000003, 24'h123456 ^ 24'h000100}, 16'h1234);
    chk("R8", "first failing half wins", 32'(status), 32'd2);
  endtask

  task automatic t_narrow;
    run_case("R9", 1'b0, {24'h345678, 24'h123456},
             {24'h345679, bad_bit(24'h123456, 8'h07, 3'd4)}, 16'hC3C3);
    chk("R9", "hi byte passthrough", 32'(data_out[15:8]), 32'h00C3);
    chk("R9", "status from half0", 32'(status), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_clean;
    t_code_bad;
    t_single_fix;
    t_uncorr;
    t_wide_both;
    t_wide_fail;
    t_narrow;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule